// File: doc/BRIEF.md
# Pipeline Memory-Access Stage

This block is the data-memory step of a simple in-order pipeline. It takes one decoded instruction at a time from the stage before it. Each instruction has an opcode and two operand words, A and B. A load reads one word at the address in operand A and puts the word into operand B. A store writes operand A to the address in operand B. Any other opcode goes through the stage with its fields unchanged.

The stage uses one word-wide memory port. The port answers each request in the same cycle with an OK flag. While the port refuses, the stage keeps the instruction and raises a stall flag. It sends the same request again in every cycle, with address, data and direction unchanged, until the port takes it. Handshakes with valid and ready flags link the stage to its neighbours. A squash input turns a held instruction into a no-operation and drops any request that has not finished.

Top module: `mstage_top`

## Requirements
- R1: After reset, `out_valid`, `mem_req` and `stalled` are low and `in_ready` is high.
- R2: Opcode encodings: 0 is the no-operation, 1 is a load and 2 is a store. When a load is held and not yet done, `mem_req` is high, `mem_we` is low and `mem_addr` equals operand A.
- R3: When the load's request is met with `mem_ok`, the word on `mem_rdata` becomes the output operand B. The opcode and operand A leave the stage unchanged.
- R4: When a store is held and not yet done, `mem_req` and `mem_we` are high, `mem_addr` equals operand B and `mem_wdata` equals operand A. The instruction leaves with all fields unchanged.
- R5: In a cycle where `mem_req` is high and `mem_ok` is low, `stalled` is high and `out_valid` is low. In the next cycle the same request (address, data and direction) is presented again.
- R6: Any opcode other than load or store makes no memory request. It is offered on the output in the first cycle after it is accepted, with its fields unchanged.
- R7: An instruction leaves only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the output holds steady and `in_ready` stays low.
- R8: A squash while an instruction is held drops the memory request in that same cycle. In the next cycle the instruction is offered with opcode 0 and makes no further request, so a squashed store never writes memory.
- R9: With `mem_ok` high on the first try, a load or store is offered on the output exactly one cycle after acceptance. Each refused try adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| squash_i | input | 1 | Flush the held instruction into a no-operation |
| in_valid | input | 1 | Upstream offers an instruction |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| in_op | input | OP_W | Opcode of the offered instruction |
| in_opa | input | DW | Operand A |
| in_opb | input | DW | Operand B |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DW | Write data |
| mem_ok | input | 1 | Port accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ok` |
| out_valid | output | 1 | Finished instruction offered downstream |
| out_ready | input | 1 | Downstream takes the instruction |
| out_op | output | OP_W | Opcode out |
| out_opa | output | DW | Operand A out |
| out_opb | output | DW | Operand B out |
| stalled | output | 1 | Memory request refused this cycle |

## Verification
The assertions check, on every cycle, that:
- a refused request is repeated with the same address, data and direction;
- a stall never shows as an output;
- the output holds steady under backpressure;
- a pass-through instruction never touches memory;
- a squash leaves a no-operation that makes no request.

Only the bench scenarios can show that load data arrives in operand B and that stores land at the right word. They also show the exact latency for a given number of refusals, and that a squashed store leaves memory untouched.

// File: rtl/mstage_pkg.sv
package mstage_pkg;

   typedef enum logic [1:0] {
      K_PASS  = 2'd0,
      K_LOAD  = 2'd1,
      K_STORE = 2'd2
   } kind_e;

   function automatic logic is_mem(input kind_e k);
      return (k == K_LOAD) || (k == K_STORE);
   endfunction

endpackage

// File: rtl/mstage_decode.sv
module mstage_decode
   import mstage_pkg::*;
#(
   parameter int OP_W       = 4,
   parameter int LOAD_CODE  = 1,
   parameter int STORE_CODE = 2
) (
   input  logic [OP_W-1:0] op,
   output kind_e           kind
);

   localparam logic [OP_W-1:0] LD = OP_W'(LOAD_CODE);
   localparam logic [OP_W-1:0] ST = OP_W'(STORE_CODE);

   generate
      if (LOAD_CODE == STORE_CODE) begin : g_bad_codes
         $error("mstage_decode: load and store codes must differ");
      end
      if (LOAD_CODE >= (1 << OP_W) || STORE_CODE >= (1 << OP_W)) begin : g_bad_width
         $error("mstage_decode: opcode does not fit OP_W");
      end
   endgenerate

   always_comb begin
      if (op == LD)      kind = K_LOAD;
      else if (op == ST) kind = K_STORE;
      else               kind = K_PASS;
   end

endmodule

// File: rtl/mstage_slot.sv
module mstage_slot
   import mstage_pkg::*;
#(
   parameter int DW       = 32,
   parameter int OP_W     = 4,
   parameter int NOP_CODE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            leave,
   input  logic            squash,
   input  logic            mem_done,
   input  logic [OP_W-1:0] in_op,
   input  logic [DW-1:0]   in_a,
   input  logic [DW-1:0]   in_b,
   input  kind_e           in_kind,
   input  logic [DW-1:0]   rdata,
   output logic            vld,
   output logic            done,
   output kind_e           kind,
   output logic [OP_W-1:0] op,
   output logic [DW-1:0]   a,
   output logic [DW-1:0]   b
);

   localparam logic [OP_W-1:0] NOP_V = OP_W'(NOP_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         done <= 1'b0;
         kind <= K_PASS;
         op   <= NOP_V;
         a    <= '0;
         b    <= '0;
      end else if (take) begin
         vld  <= 1'b1;
         done <= !is_mem(in_kind);
         kind <= in_kind;
         op   <= in_op;
         a    <= in_a;
         b    <= in_b;
      end else if (leave) begin
         vld  <= 1'b0;
      end else if (vld && squash) begin
         op   <= NOP_V;
         kind <= K_PASS;
         done <= 1'b1;
      end else if (mem_done) begin
         done <= 1'b1;
         if (kind == K_LOAD) b <= rdata;
      end
   end

endmodule

// File: rtl/mstage_memport.sv
module mstage_memport
   import mstage_pkg::*;
#(
   parameter int DW     = 32,
   parameter int ADDR_W = 32
) (
   input  logic              active,
   input  kind_e             kind,
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   input  logic              mem_ok,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic              mem_done,
   output logic              refused
);

   logic [DW-1:0] full_addr;

   assign full_addr = (kind == K_STORE) ? b : a;
   assign mem_req   = active && is_mem(kind);
   assign mem_we    = mem_req && (kind == K_STORE);
   assign mem_wdata = a;
   assign mem_done  = mem_req && mem_ok;
   assign refused   = mem_req && !mem_ok;

   generate
      if (ADDR_W > DW) begin : g_bad
         $error("mstage_memport: ADDR_W wider than DW");
      end else if (ADDR_W == DW) begin : g_full
         assign mem_addr = full_addr;
      end else begin : g_trunc
         assign mem_addr = full_addr[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/mstage_top.sv
module mstage_top
   import mstage_pkg::*;
#(
   parameter int DW         = 32,
   parameter int ADDR_W     = 32,
   parameter int OP_W       = 4,
   parameter int NOP_CODE   = 0,
   parameter int LOAD_CODE  = 1,
   parameter int STORE_CODE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              squash_i,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OP_W-1:0]   in_op,
   input  logic [DW-1:0]     in_opa,
   input  logic [DW-1:0]     in_opb,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_ok,
   input  logic [DW-1:0]     mem_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OP_W-1:0]   out_op,
   output logic [DW-1:0]     out_opa,
   output logic [DW-1:0]     out_opb,
   output logic              stalled
);

   localparam logic [OP_W-1:0] NOP_V = OP_W'(NOP_CODE);

   generate
      if (NOP_CODE == LOAD_CODE || NOP_CODE == STORE_CODE) begin : g_bad_nop
         $error("mstage_top: no-operation code collides with a memory code");
      end
   endgenerate

   kind_e in_kind, kind;
   logic  vld, done, take, leave, mem_done, active;

   mstage_decode #(.OP_W(OP_W), .LOAD_CODE(LOAD_CODE), .STORE_CODE(STORE_CODE)) u_dec (
      .op   (in_op),
      .kind (in_kind)
   );

   assign out_valid = vld && done && !squash_i;
   assign leave     = out_valid && out_ready;
   assign in_ready  = !squash_i && (!vld || leave);
   assign take      = in_valid && in_ready;
   assign active    = vld && !done && !squash_i;

   mstage_slot #(.DW(DW), .OP_W(OP_W), .NOP_CODE(NOP_CODE)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .leave    (leave),
      .squash   (squash_i),
      .mem_done (mem_done),
      .in_op    (in_op),
      .in_a     (in_opa),
      .in_b     (in_opb),
      .in_kind  (in_kind),
      .rdata    (mem_rdata),
      .vld      (vld),
      .done     (done),
      .kind     (kind),
      .op       (out_op),
      .a        (out_opa),
      .b        (out_opb)
   );

   mstage_memport #(.DW(DW), .ADDR_W(ADDR_W)) u_mem (
      .active    (active),
      .kind      (kind),
      .a         (out_opa),
      .b         (out_opb),
      .mem_ok    (mem_ok),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_done  (mem_done),
      .refused   (stalled)
   );

   AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ok && !squash_i) |=> squash_i ||
      (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we))); // R5

   AST_STALL_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> !out_valid); // R5

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !squash_i) |=> squash_i ||
      (out_valid && $stable(out_op) && $stable(out_opa) && $stable(out_opb))); // R7

   AST_PASS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !mem_req); // R6

   AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_i && vld && !$past(squash_i)) |=> (out_op == NOP_V) && !mem_req); // R8

   AST_SQUASH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i |-> !mem_req && !out_valid); // R8

endmodule

// File: tb/tb_mstage_top.sv
`timescale 1ns/1ps
module tb_mstage_top;

   localparam int DW = 32;
   localparam int OP_W = 4;
   localparam int NV = 8;
   localparam int VW = OP_W + DW + DW + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic squash_i = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [OP_W-1:0] in_op = '0;
   logic [DW-1:0] in_opa = '0, in_opb = '0;
   logic mem_req, mem_we, mem_ok, out_valid, stalled;
   logic out_ready = 1'b1;
   logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
   logic [OP_W-1:0] out_op;
   logic [DW-1:0] out_opa, out_opb;

   int compared = 0;
   int mismatched = 0;
   int deny_target = 0;
   int req_run;
   logic [DW-1:0] bmem [16];

   always #2.5 clk = ~clk;

   mstage_top dut (
      .clk(clk), .rst_n(rst_n), .squash_i(squash_i),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_opa(in_opa), .in_opb(in_opb),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ok(mem_ok), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_op(out_op), .out_opa(out_opa), .out_opb(out_opb),
      .stalled(stalled)
   );

   assign mem_ok    = (req_run >= deny_target);
   assign mem_rdata = bmem[mem_addr[3:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         req_run <= 0;
         for (int i = 0; i < 16; i++) bmem[i] <= 32'hA000_0000 + i * 17;
      end else begin
         req_run <= (mem_req && !mem_ok) ? req_run + 1 : 0;
         if (mem_req && mem_ok && mem_we) bmem[mem_addr[3:0]] <= mem_wdata;
      end
   end

   // op, opA, opB, refusals
   localparam logic [VW-1:0] VEC [NV] = '{
      {4'd1, 32'd3,          32'd0,          4'd0},
      {4'd2, 32'hDEAD_BEEF,  32'd5,          4'd0},
      {4'd1, 32'd5,          32'd7,          4'd2},
      {4'd7, 32'h0000_1234,  32'h0000_5678,  4'd0},
      {4'd0, 32'h1111_1111,  32'h2222_2222,  4'd0},
      {4'd2, 32'h0000_0042,  32'd9,          4'd3},
      {4'd1, 32'd9,          32'd1,          4'd1},
      {4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFE,  4'd0}
   };

   task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [OP_W-1:0] op, input logic [DW-1:0] a,
                          input logic [DW-1:0] b, input int d);
      logic [DW-1:0] exp_b, first_addr;
      int waits, stalls;
      bit is_ld, is_st;
      is_ld = (op == 4'd1);
      is_st = (op == 4'd2);
      exp_b = is_ld ? bmem[a[3:0]] : b;
      @(negedge clk);
      deny_target = d;
      in_valid = 1'b1; in_op = op; in_opa = a; in_opb = b;
      #1 chk(in_ready, "R7 in_ready while empty", {31'b0, in_ready}, 1);
      @(posedge clk);
      #0.5 in_valid = 1'b0;
      waits = 0; stalls = 0; first_addr = '0;
      forever begin
         @(negedge clk);
         #0.5;
         if (out_valid || waits > 40) break;
         if (stalled) stalls++;
         if (is_ld) chk(mem_req && !mem_we && mem_addr == a, "R2 load request",
                        mem_addr, a);
         if (is_st) chk(mem_req && mem_we && mem_addr == b && mem_wdata == a,
                        "R4 store request", mem_wdata, a);
         if (waits == 0) first_addr = mem_addr;
         else chk(mem_addr == first_addr, "R5 retry address stable", mem_addr, first_addr);
         waits++;
      end
      chk(waits == ((is_ld || is_st) ? d + 1 : 0), "R9/R6 latency", waits,
          (is_ld || is_st) ? d + 1 : 0);
      chk(stalls == ((is_ld || is_st) ? d : 0), "R5 stall cycles", stalls,
          (is_ld || is_st) ? d : 0);
      chk(out_op == op, "R3/R6 opcode unchanged", {28'b0, out_op}, {28'b0, op});
      chk(out_opa == a, "R3/R4 operand A unchanged", out_opa, a);
      chk(out_opb == exp_b, is_ld ? "R3 load data" : "R6 operand B unchanged",
          out_opb, exp_b);
      chk(!mem_req, "R6 no request on output", {31'b0, mem_req}, 0);
      @(posedge clk);
      #0.5;
      if (is_st) chk(bmem[b[3:0]] == a, "R4 store landed", bmem[b[3:0]], a);
   endtask

   initial begin
      #(200000 * 5);
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [DW-1:0] saved;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      chk(!out_valid, "R1 out_valid reset", {31'b0, out_valid}, 0);
      chk(!mem_req, "R1 mem_req reset", {31'b0, mem_req}, 0);
      chk(!stalled, "R1 stalled reset", {31'b0, stalled}, 0);
      chk(in_ready, "R1 in_ready reset", {31'b0, in_ready}, 1);

      for (int v = 0; v < NV; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         run_one(e[VW-1 -: OP_W], e[DW+DW+3 -: DW], e[DW+3 -: DW], int'(e[3:0]));
      end

      // backpressure on a pass-through instruction
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_op = 4'd6; in_opa = 32'h55; in_opb = 32'h66;
      @(posedge clk);
      #0.5 in_valid = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         #0.5;
         chk(out_valid && out_opb == 32'h66, "R7 held under backpressure", out_opb, 32'h66);
         chk(!in_ready, "R7 in_ready low while held", {31'b0, in_ready}, 0);
      end
      out_ready = 1'b1;
      @(posedge clk);
      #0.5 chk(!out_valid, "R7 leaves after ready", {31'b0, out_valid}, 0);

      // squash a refused store
      saved = bmem[4];
      @(negedge clk);
      deny_target = 10;
      in_valid = 1'b1; in_op = 4'd2; in_opa = 32'hBAD0_0BAD; in_opb = 32'd4;
      @(posedge clk);
      #0.5 in_valid = 1'b0;
      @(negedge clk);
      #0.5 chk(stalled && mem_req, "R5 stalled before squash", {31'b0, stalled}, 1);
      @(negedge clk);
      squash_i = 1'b1;
      #0.5 chk(!mem_req, "R8 request dropped in squash cycle", {31'b0, mem_req}, 0);
      @(negedge clk);
      squash_i = 1'b0;
      deny_target = 0;
      #0.5;
      chk(out_valid && out_op == 4'd0, "R8 squashed becomes no-op", {28'b0, out_op}, 0);
      chk(!mem_req, "R8 no request after squash", {31'b0, mem_req}, 0);
      @(posedge clk);
      #0.5 chk(bmem[4] == saved, "R8 squashed store not written", bmem[4], saved);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule